// File: doc/BRIEF.md
# Legacy BIOS Window Attribute Router

This block sits in a memory request path and decides where requests aimed at the 768 KB to 1 MB window (0xC0000 to 0xFFFFF) are delivered. The window is split into thirteen sections. Each section carries one read-permit bit and one write-permit bit. For processor requests, these bits choose between system DRAM and the downstream I/O link.

Requests that arrive from the I/O side follow fixed rules. Snooped requests are flagged so the caller can snoop the processor caches. Non-snooped requests always go to DRAM. A graphics-translated request that lands in the window is a mapping error: it is redirected to the window's first byte, and a write loses all its byte enables. Addresses outside the window pass through unchanged and are marked as such.

Each accepted request produces one registered result one clock later.

Top module: `pam_router`

## Requirements
- R1: A request presented with `req_valid` high yields its result on the outputs one clock edge later, with `out_valid` high. A cycle with `req_valid` low drops `out_valid` at the next edge. While `rst_n` is low at a clock edge, every output is cleared to zero.
- R2: The window has thirteen sections, and bit i of each attribute vector governs section i. Sections 0 to 11 are 16 KB each and start at 0xC0000, so section i begins at 0xC0000 + i*0x4000. Section 12 is one 64 KB span from 0xF0000 to 0xFFFFF.
- R3: Origin encoding is 0 = processor, 1 = I/O snooped, 2 = I/O non-snooped, 3 = graphics-translated. Destination encoding is 0 = DRAM, 1 = downstream link. A processor read in the window goes to DRAM when the section's read-permit bit is 1 and to the link when it is 0. A processor write uses the write-permit bit in the same way.
- R4: An I/O snooped request (origin 1) in the window raises `out_snoop` and is routed by the section attributes exactly like a processor request.
- R5: An I/O non-snooped request (origin 2) in the window always goes to DRAM with `out_snoop` low, whatever the attribute bits hold.
- R6: A graphics-translated request (origin 3) in the window raises `out_error`, returns address 0xC0000 and destination DRAM. A read keeps its byte enables.
- R7: A graphics-translated write in the window leaves with every byte enable cleared to zero.
- R8: Any request outside 0xC0000 to 0xFFFFF, including graphics-translated ones, returns `out_in_region` low, its own address and byte enables, destination DRAM, and `out_snoop` and `out_error` low.
- R9: Every request inside the window returns `out_in_region` high. Non-graphics requests return their address and byte enables unchanged. The attribute bits are sampled in the same cycle as the request they govern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W (32) | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_origin | input | 2 | Originator code (see R3) |
| req_be | input | BE_W (4) | Request byte enables |
| attr_rd_en | input | 13 | Per-section read permit |
| attr_wr_en | input | 13 | Per-section write permit |
| out_valid | output | 1 | Result present |
| out_dest | output | 1 | 0 = DRAM, 1 = downstream link |
| out_snoop | output | 1 | Processor caches must be snooped |
| out_error | output | 1 | Graphics-translated mapping error |
| out_in_region | output | 1 | Address fell inside the window |
| out_addr | output | ADDR_W (32) | Possibly rewritten address |
| out_be | output | BE_W (4) | Outgoing byte enables |

## Verification
Two things can change in the same cycle: a section's attribute bits, and a request that depends on them. The bench flips the read-permit and write-permit bits of one section on the same falling edge that presents a request to that section. It then expects the routing that the new bit values give, not the old ones. A graphics-translated write at the last byte of the 64 KB section is also run. That case must show the address redirect and the byte-enable clearing together, while a read of the same address keeps its enables.

// File: rtl/pam_pkg.sv
// Shared encodings for the legacy BIOS window router.
// Assumes a two-bit originator field and a one-bit destination.
package pam_pkg;
    typedef enum logic [1:0] {
        ORG_CORE    = 2'd0,
        ORG_IO_SNP  = 2'd1,
        ORG_IO_NSNP = 2'd2,
        ORG_GFX     = 2'd3
    } origin_e;

    typedef enum logic {
        DST_DRAM = 1'b0,
        DST_LINK = 1'b1
    } dest_e;
endpackage

// File: rtl/pam_section_decode.sv
// Decodes a byte address into a one-hot section vector for the attribute window.
// Assumes the small sections are contiguous and the large section directly follows them.
module pam_section_decode #(
    parameter int ADDR_W      = 32,
    parameter int WIN_BASE    = 32'h000C_0000,
    parameter int SMALL_BYTES = 32'h4000,
    parameter int NUM_SMALL   = 12,
    parameter int BIG_BYTES   = 32'h1_0000
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SMALL:0]   sec_hit,
    output logic                 in_window
);
    localparam int NUM_SEC = NUM_SMALL + 1;
    localparam logic [ADDR_W:0] BIG_LO = (ADDR_W+1)'(WIN_BASE) + (ADDR_W+1)'(NUM_SMALL * SMALL_BYTES);

    logic [ADDR_W:0] a_ext;
    assign a_ext = {1'b0, addr};

    // One comparator pair per section, generated from the section geometry.
    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        localparam logic [ADDR_W:0] LO = (s < NUM_SMALL) ?
            (ADDR_W+1)'(WIN_BASE) + (ADDR_W+1)'(s * SMALL_BYTES) : BIG_LO;
        localparam logic [ADDR_W:0] HI = (s < NUM_SMALL) ?
            LO + (ADDR_W+1)'(SMALL_BYTES) : BIG_LO + (ADDR_W+1)'(BIG_BYTES);
        assign sec_hit[s] = (a_ext >= LO) && (a_ext < HI);
    end

    // Window membership is any section hit.
    assign in_window = |sec_hit;
endmodule

// File: rtl/pam_route_policy.sv
// Combinational routing policy: picks destination, snoop flag, error, address and byte enables.
// Assumes the selected section's permit bits are already extracted by the caller.
module pam_route_policy
    import pam_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BE_W     = 4,
    parameter int ERR_ADDR = 32'h000C_0000
) (
    input  logic              in_window,
    input  logic              sec_rd_ok,
    input  logic              sec_wr_ok,
    input  logic              is_write,
    input  origin_e           origin,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    output dest_e             dest,
    output logic              snoop,
    output logic              error,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BE_W-1:0]   be_o
);
    logic permit;

    // Permit bit for the access direction.
    assign permit = is_write ? sec_wr_ok : sec_rd_ok;

    // Decide all result fields from origin and window membership.
    always_comb begin
        dest   = DST_DRAM;
        snoop  = 1'b0;
        error  = 1'b0;
        addr_o = addr_i;
        be_o   = be_i;
        if (in_window) begin
            unique case (origin)
                ORG_CORE:    dest = permit ? DST_DRAM : DST_LINK;
                ORG_IO_SNP: begin
                    dest  = permit ? DST_DRAM : DST_LINK;
                    snoop = 1'b1;
                end
                ORG_IO_NSNP: dest = DST_DRAM;
                ORG_GFX: begin
                    error  = 1'b1;
                    addr_o = ADDR_W'(ERR_ADDR);
                    if (is_write) be_o = '0;
                end
                default:     dest = DST_DRAM;
            endcase
        end
    end
endmodule

// File: rtl/pam_router.sv
// Top of the legacy BIOS window router: decodes, applies policy, registers the result.
// Assumes one request per cycle and attribute bits valid in the request cycle.
module pam_router
    import pam_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BE_W      = 4,
    parameter int NUM_SMALL = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic [1:0]           req_origin,
    input  logic [BE_W-1:0]      req_be,
    input  logic [NUM_SMALL:0]   attr_rd_en,
    input  logic [NUM_SMALL:0]   attr_wr_en,
    output logic                 out_valid,
    output logic                 out_dest,
    output logic                 out_snoop,
    output logic                 out_error,
    output logic                 out_in_region,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [BE_W-1:0]      out_be
);
    localparam int          WIN_BASE = 32'h000C_0000;
    localparam logic [ADDR_W-1:0] ERR_A = ADDR_W'(WIN_BASE);

    logic [NUM_SMALL:0] sec_hit;
    logic               in_window;
    logic               sec_rd_ok, sec_wr_ok;
    dest_e              nxt_dest;
    logic               nxt_snoop, nxt_error;
    logic [ADDR_W-1:0]  nxt_addr;
    logic [BE_W-1:0]    nxt_be;
    origin_e            origin;

    assign origin = origin_e'(req_origin);

    pam_section_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SMALL_BYTES(32'h4000),
        .NUM_SMALL(NUM_SMALL), .BIG_BYTES(32'h1_0000)
    ) i_dec (
        .addr(req_addr), .sec_hit(sec_hit), .in_window(in_window)
    );

    // Pick the permit bits of the one section that was hit.
    assign sec_rd_ok = |(sec_hit & attr_rd_en);
    assign sec_wr_ok = |(sec_hit & attr_wr_en);

    pam_route_policy #(
        .ADDR_W(ADDR_W), .BE_W(BE_W), .ERR_ADDR(WIN_BASE)
    ) i_pol (
        .in_window(in_window), .sec_rd_ok(sec_rd_ok), .sec_wr_ok(sec_wr_ok),
        .is_write(req_write), .origin(origin), .addr_i(req_addr), .be_i(req_be),
        .dest(nxt_dest), .snoop(nxt_snoop), .error(nxt_error),
        .addr_o(nxt_addr), .be_o(nxt_be)
    );

    // Result register: capture on a valid request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_dest      <= 1'b0;
            out_snoop     <= 1'b0;
            out_error     <= 1'b0;
            out_in_region <= 1'b0;
            out_addr      <= '0;
            out_be        <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_dest      <= nxt_dest;
                out_snoop     <= nxt_snoop;
                out_error     <= nxt_error;
                out_in_region <= in_window;
                out_addr      <= nxt_addr;
                out_be        <= nxt_be;
            end
        end
    end

    // R2
    sec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sec_hit));

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R5
    nsnp_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_window && req_origin == 2'd2) |=> (out_dest == 1'b0 && !out_snoop));

    // R6
    gfx_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_window && req_origin == 2'd3) |=> (out_error && out_addr == ERR_A));

    // R7
    gfx_wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_window && req_origin == 2'd3 && req_write) |=> (out_be == '0));

    // R8
    outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_window) |=> (!out_in_region && !out_error && !out_snoop
                                       && out_addr == $past(req_addr) && out_be == $past(req_be)));

    // R4
    snp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_window && req_origin == 2'd1) |=> out_snoop);
endmodule

// File: tb/test_pam_router.sv
`timescale 1ns/1ps
module test_pam_router;
    localparam int AW = 32;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_write;
    logic [1:0]    req_origin;
    logic [BW-1:0] req_be;
    logic [12:0]   attr_rd_en, attr_wr_en;
    logic          out_valid, out_dest, out_snoop, out_error, out_in_region;
    logic [AW-1:0] out_addr;
    logic [BW-1:0] out_be;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pam_router i_pam_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_origin(req_origin), .req_be(req_be),
        .attr_rd_en(attr_rd_en), .attr_wr_en(attr_wr_en),
        .out_valid(out_valid), .out_dest(out_dest), .out_snoop(out_snoop),
        .out_error(out_error), .out_in_region(out_in_region),
        .out_addr(out_addr), .out_be(out_be)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent model of the requirements; returns section index or -1.
    function automatic int sec_of(input logic [31:0] a);
        if (a < 32'hC0000 || a > 32'hFFFFF) return -1;
        if (a >= 32'hF0000) return 12;
        return int'((a - 32'hC0000) / 32'h4000);
    endfunction

    // Drive one request at a falling edge and check the registered result one edge later.
    task automatic send(input string req, input logic [31:0] a, input logic w,
                        input logic [1:0] org, input logic [3:0] be);
        int s;
        logic perm, e_dest, e_snp, e_err, e_in;
        logic [31:0] e_addr;
        logic [3:0] e_be;
        s = sec_of(a);
        e_in = (s >= 0);
        e_dest = 1'b0; e_snp = 1'b0; e_err = 1'b0; e_addr = a; e_be = be;
        if (e_in) begin
            perm = w ? attr_wr_en[s] : attr_rd_en[s];
            if (org == 2'd0) e_dest = !perm;
            else if (org == 2'd1) begin e_dest = !perm; e_snp = 1'b1; end
            else if (org == 2'd3) begin
                e_err = 1'b1; e_addr = 32'hC0000;
                if (w) e_be = 4'h0;
            end
        end
        req_valid = 1'b1; req_addr = a; req_write = w; req_origin = org; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "valid",  {31'd0, out_valid}, 32'd1);
        chk(req, "dest",   {31'd0, out_dest}, {31'd0, e_dest});
        chk(req, "snoop",  {31'd0, out_snoop}, {31'd0, e_snp});
        chk(req, "error",  {31'd0, out_error}, {31'd0, e_err});
        chk(req, "in_reg", {31'd0, out_in_region}, {31'd0, e_in});
        chk(req, "addr",   out_addr, e_addr);
        chk(req, "be",     {28'd0, out_be}, {28'd0, e_be});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b1; req_addr = 32'hC0000; req_write = 1'b0;
        req_origin = 2'd3; req_be = 4'hF; attr_rd_en = '1; attr_wr_en = '1;
        @(negedge clk); @(negedge clk);
        chk("R1", "reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "reset error", {31'd0, out_error}, 32'd0);
        chk("R1", "reset addr", out_addr, 32'd0);
        chk("R1", "reset be", {28'd0, out_be}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2 R3: section boundaries with alternating permit patterns.
    task automatic t_core_sections();
        attr_rd_en = 13'b1_0101_0101_0101;
        attr_wr_en = 13'b0_1010_1010_1010;
        for (int s = 0; s < 12; s++) begin
            send("R2", 32'hC0000 + s * 32'h4000, 1'b0, 2'd0, 4'hF);
            send("R3", 32'hC0000 + s * 32'h4000 + 32'h3FFF, 1'b1, 2'd0, 4'h3);
        end
        send("R2", 32'hF0000, 1'b0, 2'd0, 4'h1);
        send("R2", 32'hFFFFF, 1'b1, 2'd0, 4'h8);
        attr_rd_en = '0; attr_wr_en = '1;
        send("R3", 32'hD4000, 1'b0, 2'd0, 4'hF);
        send("R3", 32'hD4000, 1'b1, 2'd0, 4'hF);
    endtask

    task automatic t_snooped();
        attr_rd_en = 13'h0F0F; attr_wr_en = 13'h10F0;
        send("R4", 32'hC8000, 1'b0, 2'd1, 4'hF);
        send("R4", 32'hE4000, 1'b1, 2'd1, 4'h6);
        send("R4", 32'hF8000, 1'b1, 2'd1, 4'hC);
    endtask

    task automatic t_nonsnooped();
        attr_rd_en = '0; attr_wr_en = '0;
        send("R5", 32'hC0000, 1'b0, 2'd2, 4'hF);
        send("R5", 32'hFFFFC, 1'b1, 2'd2, 4'h9);
        send("R9", 32'hDC123, 1'b1, 2'd2, 4'h5);
    endtask

    task automatic t_graphics();
        attr_rd_en = '1; attr_wr_en = '1;
        send("R6", 32'hE8010, 1'b0, 2'd3, 4'hA);
        send("R7", 32'hFFFFF, 1'b1, 2'd3, 4'hF);
        send("R6", 32'hFFFFF, 1'b0, 2'd3, 4'hF);
        send("R7", 32'hC0000, 1'b1, 2'd3, 4'h1);
    endtask

    task automatic t_outside();
        attr_rd_en = '1; attr_wr_en = '0;
        send("R8", 32'hBFFFF, 1'b1, 2'd3, 4'hF);
        send("R8", 32'h100000, 1'b0, 2'd1, 4'h7);
        send("R8", 32'h800C0000, 1'b1, 2'd0, 4'h2);
    endtask

    // R9: attribute change lands in the same cycle as the request it governs.
    task automatic t_same_cycle();
        attr_rd_en = '0; attr_wr_en = '0;
        @(negedge clk);
        attr_rd_en[5] = 1'b1;
        send("R9", 32'hD4100, 1'b0, 2'd0, 4'hF);
        attr_wr_en[12] = 1'b1; attr_rd_en[12] = 1'b0;
        send("R9", 32'hF4000, 1'b1, 2'd0, 4'hF);
        attr_wr_en[12] = 1'b0;
        send("R9", 32'hF4000, 1'b1, 2'd0, 4'hF);
    endtask

    // R1: idle cycle drops valid.
    task automatic t_idle();
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1", "idle valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_core_sections();
        t_snooped();
        t_nonsnooped();
        t_graphics();
        t_outside();
        t_same_cycle();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule